// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block decides when an embedded program or erase operation inside a parallel NOR flash has ended. After the operation's command sequence has been written, the controller pulses `start_i`. The block then keeps chip enable asserted and issues back-to-back status reads at a latched address. Each read has its own address setup, output-enable low and output-enable recovery windows, counted in clock cycles. The result is inferred from how status bits behave from one read to the next; the device exposes no ready flag here.

Two detection methods are available. Data-bit polling compares bit 7 of each read with bit 7 of the expected final data. That bit stays complemented while the device is busy. Toggle polling compares bit 6 of consecutive reads. That bit flips on every read while busy and holds still once the operation is over. A confirming array read is then made, and it must return the full expected word. When the device raises its internal-limit flag (bit 5) during a busy read, the block allows exactly one further read before it declares failure. A cycle budget ends polling with a timeout if no completion is seen in time.

Top module: `nor_status_poller`

## Requirements
- R1: During and right after reset, `busy_o` is low, `ce_n_o` and `oe_n_o` are high, and `done_o`, `fail_o` and `tmo_o` are low.
- R2: Each status read keeps `ce_n_o` low and `addr_o` equal to the address latched at start. `oe_n_o` stays high for at least SETUP_CYC cycles before it falls. It then stays low for exactly ACC_CYC cycles, and `rd_data_i` is sampled on the last of those cycles.
- R3: Between two consecutive reads, `oe_n_o` is high for at least GAP_CYC + SETUP_CYC cycles.
- R4: With `mode_i` = 0 (data-bit polling), the first read whose bit 7 equals bit 7 of `expect_i` ends polling with `done_o`, and no further read follows.
- R5: In mode 0, a read whose bit 7 mismatches while bit 5 is 1 is followed by exactly one more read. If that read's bit 7 still mismatches, `fail_o` is raised; if it matches, `done_o` is raised.
- R6: With `mode_i` = 1 (toggle polling), two consecutive reads whose bit 6 agree trigger one confirming read. `done_o` is raised if that read equals `expect_i` on all bits, and `fail_o` otherwise.
- R7: In mode 1, a read whose bit 6 differs from the previous read while bit 5 is 1 allows one more read. If bit 6 differs again, `fail_o` is raised.
- R8: If a status read (not a confirming read) would begin TIMEOUT_CYC or more cycles after start, `tmo_o` is raised instead, and no further read is made.
- R9: A `start_i` pulse while `busy_o` is high is ignored: the address, mode, expected data and outcome of the running poll are unchanged.
- R10: `done_o`, `fail_o` and `tmo_o` are single-cycle pulses, at most one at a time. In that cycle `busy_o` is already low and `ce_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that begins a polling session |
| mode_i | input | 1 | 0 = data-bit polling, 1 = toggle polling |
| addr_i | input | AW | Address used for status reads |
| expect_i | input | DW | Final data expected at that address |
| rd_data_i | input | DW | Data bus returned by the flash read port |
| ce_n_o | output | 1 | Active-low chip enable |
| oe_n_o | output | 1 | Active-low output enable |
| addr_o | output | AW | Address driven to the flash |
| busy_o | output | 1 | Polling session in progress |
| done_o | output | 1 | Operation completed (pulse) |
| fail_o | output | 1 | Operation reported failure (pulse) |
| tmo_o | output | 1 | Polling budget exhausted (pulse) |

## Verification
The assertions check the bus discipline on every cycle. Output enable is only low while chip enable is low. The address holds during each access. The low window has exactly its length, and the high window before each fall is at least the recovery time. The result pulses are exclusive and coincide with the end of the session. They also check that a start pulse during a session leaves the latched address untouched. Only the bench's scenarios show the decisions: which read sequence ends in done, failure or timeout, the number of reads each outcome costs, the single-retry rule after the limit flag, and the confirming read in toggle mode.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [2:0] {
    V_AGAIN,
    V_RETRY,
    V_CONFIRM,
    V_DONE,
    V_FAIL
  } verdict_e;

  typedef enum logic [1:0] {
    T_IDLE,
    T_SETUP,
    T_ACC,
    T_REC
  } rd_phase_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_ISSUE,
    P_WAIT
  } poll_phase_e;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;

  localparam logic MODE_DATA   = 1'b0;
  localparam logic MODE_TOGGLE = 1'b1;

  // bits needed for a down/up counter reaching the largest of three limits
  function automatic int cnt_bits(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // data-bit method: polled bit has reached its final value
  function automatic logic bit_settled(input logic cur, input logic want);
    return cur == want;
  endfunction

  // toggle method: bit held still between two reads
  function automatic logic bit_stopped(input logic cur, input logic prev);
    return cur == prev;
  endfunction

endpackage

// File: rtl/nor_read_timer.sv
module nor_read_timer
  import nor_poll_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 4,
  parameter int ACC_CYC   = 14,
  parameter int GAP_CYC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  output logic          ready_o,
  input  logic [DW-1:0] bus_i,
  output logic          oe_n_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);

  localparam int CW  = cnt_bits(SETUP_CYC, ACC_CYC, GAP_CYC);
  localparam int LW  = $clog2(ACC_CYC + 2);
  localparam int HW  = $clog2(GAP_CYC + SETUP_CYC + 2) + 1;

  rd_phase_e     st;
  logic [CW-1:0] cnt;
  logic          last_setup, last_acc, last_rec;

  assign last_setup = (cnt == CW'(SETUP_CYC - 1));
  assign last_acc   = (cnt == CW'(ACC_CYC - 1));
  assign last_rec   = (cnt == CW'(GAP_CYC - 1));

  assign ready_o = (st == T_IDLE);
  assign oe_n_o  = (st != T_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      cnt     <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        T_IDLE: if (req_i) begin
          st  <= T_SETUP;
          cnt <= '0;
        end
        T_SETUP: if (last_setup) begin
          st  <= T_ACC;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        T_ACC: if (last_acc) begin
          st      <= T_REC;
          cnt     <= '0;
          data_o  <= bus_i;
          valid_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        T_REC: if (last_rec) begin
          st  <= T_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= T_IDLE;
      endcase
    end
  end

  // observation counters for the window checks
  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '1;
    end else if (!oe_n_o) begin
      lo_run <= lo_run + 1'b1;
      hi_run <= '0;
    end else begin
      lo_run <= '0;
      if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end
  end

  // R2
  acc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n_o) |-> (lo_run == LW'(ACC_CYC)));

  // R3
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n_o) |-> (hi_run >= HW'(GAP_CYC + SETUP_CYC)));

  // R2
  sample_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(oe_n_o));

endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
  import nor_poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          mode_i,
  input  logic          first_i,
  input  logic          retry_i,
  input  logic          confirm_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] prev_i,
  input  logic [DW-1:0] want_i,
  output verdict_e      verdict_o
);

  logic settled, stopped, limit;

  assign settled = bit_settled(cur_i[POLL_BIT], want_i[POLL_BIT]);
  assign stopped = bit_stopped(cur_i[TOGGLE_BIT], prev_i[TOGGLE_BIT]);
  assign limit   = cur_i[LIMIT_BIT];

  always_comb begin
    verdict_o = V_AGAIN;
    if (confirm_i) begin
      verdict_o = (cur_i == want_i) ? V_DONE : V_FAIL;
    end else if (mode_i == MODE_DATA) begin
      if (settled)      verdict_o = V_DONE;
      else if (retry_i) verdict_o = V_FAIL;
      else if (limit)   verdict_o = V_RETRY;
      else              verdict_o = V_AGAIN;
    end else begin
      if (first_i)      verdict_o = V_AGAIN;
      else if (stopped) verdict_o = V_CONFIRM;
      else if (retry_i) verdict_o = V_FAIL;
      else if (limit)   verdict_o = V_RETRY;
      else              verdict_o = V_AGAIN;
    end
  end

endmodule

// File: rtl/nor_status_poller.sv
module nor_status_poller
  import nor_poll_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 20,
  parameter int SETUP_CYC   = 4,
  parameter int ACC_CYC     = 14,
  parameter int GAP_CYC     = 3,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          tmo_o
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  poll_phase_e   phase;
  logic          mode_q, first_q, retry_q, confirm_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] want_q, prev_q;
  logic [TW-1:0] elapsed;

  // named internal events
  logic          rd_req, rd_ready, rd_valid, tmo_hit;
  logic [DW-1:0] rd_word;
  verdict_e      verdict;

  assign tmo_hit = (phase == P_ISSUE) && !confirm_q && (elapsed >= TW'(TIMEOUT_CYC));
  assign rd_req  = (phase == P_ISSUE) && !tmo_hit && rd_ready;
  assign busy_o  = (phase != P_IDLE);
  assign addr_o  = addr_q;

  nor_read_timer #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .ACC_CYC(ACC_CYC), .GAP_CYC(GAP_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (rd_req),
    .ready_o(rd_ready),
    .bus_i  (rd_data_i),
    .oe_n_o (oe_n_o),
    .valid_o(rd_valid),
    .data_o (rd_word)
  );

  nor_poll_judge #(.DW(DW)) u_judge (
    .mode_i   (mode_q),
    .first_i  (first_q),
    .retry_i  (retry_q),
    .confirm_i(confirm_q),
    .cur_i    (rd_word),
    .prev_i   (prev_q),
    .want_i   (want_q),
    .verdict_o(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      ce_n_o    <= 1'b1;
      mode_q    <= 1'b0;
      first_q   <= 1'b0;
      retry_q   <= 1'b0;
      confirm_q <= 1'b0;
      addr_q    <= '0;
      want_q    <= '0;
      prev_q    <= '0;
      elapsed   <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      tmo_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      tmo_o  <= 1'b0;
      if (phase != P_IDLE && elapsed < TW'(TIMEOUT_CYC)) elapsed <= elapsed + 1'b1;
      case (phase)
        P_IDLE: if (start_i) begin
          phase     <= P_ISSUE;
          ce_n_o    <= 1'b0;
          mode_q    <= mode_i;
          addr_q    <= addr_i;
          want_q    <= expect_i;
          first_q   <= 1'b1;
          retry_q   <= 1'b0;
          confirm_q <= 1'b0;
          elapsed   <= '0;
        end
        P_ISSUE: begin
          if (tmo_hit) begin
            tmo_o  <= 1'b1;
            ce_n_o <= 1'b1;
            phase  <= P_IDLE;
          end else if (rd_req) begin
            phase <= P_WAIT;
          end
        end
        P_WAIT: if (rd_valid) begin
          case (verdict)
            V_DONE: begin
              done_o <= 1'b1;
              ce_n_o <= 1'b1;
              phase  <= P_IDLE;
            end
            V_FAIL: begin
              fail_o <= 1'b1;
              ce_n_o <= 1'b1;
              phase  <= P_IDLE;
            end
            V_CONFIRM: begin
              confirm_q <= 1'b1;
              phase     <= P_ISSUE;
            end
            V_RETRY: begin
              retry_q <= 1'b1;
              first_q <= 1'b0;
              prev_q  <= rd_word;
              phase   <= P_ISSUE;
            end
            default: begin
              first_q <= 1'b0;
              prev_q  <= rd_word;
              phase   <= P_ISSUE;
            end
          endcase
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R2
  oe_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> !ce_n_o);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_o && $past(!oe_n_o)) |-> $stable(addr_o));

  // R10
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fail_o, tmo_o}));

  // R10
  result_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o || tmo_o) |-> (!busy_o && ce_n_o && $past(busy_o)));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(addr_o));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && ce_n_o && oe_n_o && !done_o && !fail_o && !tmo_o));

endmodule

// File: tb/nor_status_poller_tb.sv
module nor_status_poller_tb;

  localparam int DW = 8, AW = 20;
  localparam int SETUP_CYC = 4, ACC_CYC = 14, GAP_CYC = 3, TIMEOUT_CYC = 600;

  typedef struct {
    int    kind;    // 1 done, 2 fail, 3 timeout
    int    nreads;  // -1: any
    string tag;
  } sb_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] expv = '0, rd_data;
  logic ce_n, oe_n, busy, done, fail, tmo;
  logic [AW-1:0] addr_q;

  always #2 clk = ~clk;

  nor_status_poller #(
    .DW(DW), .AW(AW), .SETUP_CYC(SETUP_CYC), .ACC_CYC(ACC_CYC),
    .GAP_CYC(GAP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
    .expect_i(expv), .rd_data_i(rd_data), .ce_n_o(ce_n), .oe_n_o(oe_n),
    .addr_o(addr_q), .busy_o(busy), .done_o(done), .fail_o(fail), .tmo_o(tmo)
  );

  int checks = 0, errors = 0;
  int cyc = 0, start_cyc = 0, results = 0;
  int rd_cnt = 0, base = 0;
  logic [DW-1:0] script [8];
  int slen = 1;
  bit endless = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  sb_item_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // flash model: one response per status read
  function automatic logic [DW-1:0] resp(input int n);
    if (endless) return n[0] ? 8'h40 : 8'h00;
    if (n < slen) return script[n];
    return script[slen-1];
  endfunction

  always_comb rd_data = resp(rd_cnt - base);
  always @(posedge oe_n) if (rst_n) rd_cnt <= rd_cnt + 1;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor: OE windows, CE and address per read
  int lo = 0, hi = 1000;
  logic oe_prev = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!oe_n) begin
      if (oe_prev) begin
        check(hi >= GAP_CYC + SETUP_CYC, "R3 oe high window", hi, GAP_CYC + SETUP_CYC);
        check(ce_n == 1'b0, "R2 ce low at read", int'(ce_n), 0);
        check(addr_q == cur_addr, "R2 read address", int'(addr_q), int'(cur_addr));
        hi = 0;
      end
      lo++;
    end else begin
      if (!oe_prev) begin
        check(lo == ACC_CYC, "R2 oe low length", lo, ACC_CYC);
        lo = 0;
      end
      hi++;
    end
    oe_prev = oe_n;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && (done || fail || tmo)) begin
    int kind;
    sb_item_t it;
    kind = done ? 1 : (fail ? 2 : 3);
    check(int'(done) + int'(fail) + int'(tmo) == 1, "R10 single result", int'(done) + int'(fail) + int'(tmo), 1);
    check(!busy && ce_n, "R10 released at result", int'(busy), 0);
    if (sb_q.size() == 0) begin
      check(1'b0, "R10 unexpected result", kind, 0);
    end else begin
      it = sb_q.pop_front();
      check(kind == it.kind, {it.tag, " outcome"}, kind, it.kind);
      if (it.nreads >= 0)
        check(rd_cnt - base == it.nreads, {it.tag, " read count"}, rd_cnt - base, it.nreads);
      if (kind == 3)
        check(cyc - start_cyc >= TIMEOUT_CYC, "R8 timeout not early", cyc - start_cyc, TIMEOUT_CYC);
    end
    results++;
  end

  task automatic load(input logic [DW-1:0] a, b, c, d, e, input int n);
    script[0] = a; script[1] = b; script[2] = c; script[3] = d; script[4] = e;
    slen = n;
  endtask

  task automatic run(input logic m, input logic [DW-1:0] ev, input logic [AW-1:0] ad,
                     input int kind, input int nreads, input string tag);
    int target;
    sb_item_t it;
    it.kind = kind; it.nreads = nreads; it.tag = tag;
    sb_q.push_back(it);
    target = results + 1;
    @(negedge clk);
    base = rd_cnt; cur_addr = ad;
    mode = m; expv = ev; addr = ad; start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    wait (results == target);
    begin
      int after;
      after = rd_cnt;
      repeat (40) @(negedge clk);
      check(rd_cnt == after, {tag, " no read after result"}, rd_cnt - after, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    check(!busy && ce_n && oe_n && !done && !fail && !tmo, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && ce_n && oe_n, "R1 idle after reset", int'(ce_n), 1);

    // R4: bit 7 settles on fourth read (expect bit7=1)
    load(8'h40, 8'h00, 8'h05, 8'hA5, 8'hA5, 4);
    run(1'b0, 8'hA5, 20'h0_0123, 1, 4, "R4");
    // R5: limit flag then settled -> done after 3 reads
    load(8'h80, 8'hA0, 8'h3C, 8'h3C, 8'h3C, 3);
    run(1'b0, 8'h3C, 20'h1_0000, 1, 3, "R5 recover");
    // R5: limit flag then still mismatched -> fail after 2 reads
    load(8'hA0, 8'hA0, 8'hA0, 8'hA0, 8'hA0, 2);
    run(1'b0, 8'h3C, 20'h2_0004, 2, 2, "R5 fail");
    // R6: toggles, stops, confirm read matches
    load(8'h40, 8'h00, 8'h40, 8'h40, 8'h5A, 5);
    run(1'b1, 8'h5A, 20'h3_1000, 1, 5, "R6 done");
    // R6: stops, confirm read differs in bit 0
    load(8'h00, 8'h00, 8'h5B, 8'h5B, 8'h5B, 3);
    run(1'b1, 8'h5A, 20'h3_1004, 2, 3, "R6 fail");
    // R7: limit flag then still toggling -> fail
    load(8'h00, 8'h60, 8'h00, 8'h00, 8'h00, 3);
    run(1'b1, 8'h5A, 20'h4_0000, 2, 3, "R7 fail");
    // R7: limit flag then stopped -> confirm -> done
    load(8'h00, 8'h60, 8'h60, 8'h5A, 8'h5A, 4);
    run(1'b1, 8'h5A, 20'h4_0010, 1, 4, "R7 recover");
    // R8: never stops toggling
    endless = 1'b1;
    run(1'b1, 8'h5A, 20'h5_5555, 3, -1, "R8");
    endless = 1'b0;
    // R9: second start mid-session with other settings is ignored
    load(8'h40, 8'h00, 8'h05, 8'hA5, 8'hA5, 4);
    fork
      run(1'b0, 8'hA5, 20'h6_0001, 1, 4, "R9");
      begin
        repeat (30) @(negedge clk);
        mode = 1'b1; expv = 8'h00; addr = 20'hF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check(sb_q.size() == 0, "R10 all results seen", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule